// File: doc/BRIEF.md
# DRAM Power-Up and Self-Refresh Sequencer

This block sits on the controller side of an asynchronous DRAM that is driven by row and column strobes. It is the first thing to drive the strobes after reset. It keeps both strobes idle for the long power-up pause. It then runs a train of warm-up refresh cycles, either column-before-row or row-only according to a parameter, and only then reports the memory as ready. Every minimum time is given in nanoseconds and turned into a whole number of clocks, rounding up, from a clock-period parameter.

Once the memory is ready, a requester can raise a self-refresh request. The sequencer lowers the column strobe, then the row strobe, and acknowledges. It keeps the row strobe low for at least the minimum self-refresh width, even when the request is withdrawn early. On exit it may release the column strobe a few clocks before the row strobe. It then holds the row strobe high for the precharge time of the chosen speed grade before it reports ready again. The write enable stays inactive throughout, because every cycle this block issues is a refresh.

Top module: `dram_srf_seq`

## Requirements
- R1: During reset and for PAUSE_CLKS = ceil(PAUSE_NS*1000/CLK_PERIOD_PS) clocks after reset is released, ras_n and cas_n stay high, ready stays low and srf_ack stays low. The first strobe activity is seen exactly PAUSE_CLKS clocks after release.
- R2: After the pause, exactly INIT_CYCLES (at least 8) warm-up refresh pulses are issued. With INIT_CBR=1, cas_n falls exactly SETUP_CLKS clocks before each ras_n fall, and each warm-up ras_n low pulse lasts exactly INIT_RAS_CLKS clocks.
- R3: Between any ras_n rise and the next ras_n fall, ras_n stays high for at least PRE_CLKS clocks. PRE_CLKS is the precharge time rounded up: 90 ns for SPEED_GRADE 0, 110 ns for 1 and 130 ns for 2.
- R4: ready first rises exactly PAUSE_CLKS + INIT_CYCLES*(SETUP_CLKS+INIT_RAS_CLKS+PRE_CLKS) clocks after reset release. ready is high only while ras_n and cas_n are both high and srf_ack is low.
- R5: A request that is seen while ready is high makes cas_n fall on the next clock. ras_n falls SETUP_CLKS clocks later, and srf_ack rises in the same clock as ras_n falls. srf_ack is high only while both strobes are low.
- R6: A self-refresh ras_n low pulse lasts at least SRF_CLKS = ceil(SRF_MIN_NS*1000/CLK_PERIOD_PS) clocks, even when the request is released one clock after srf_ack rises.
- R7: On self-refresh exit, cas_n rises exactly LEAD_CLKS = floor(CAS_LEAD_NS*1000/CLK_PERIOD_PS) clocks before ras_n, with CAS_LEAD_NS at most 50. If the request is dropped h clocks after srf_ack rises, the ras_n low width is max(SRF_CLKS, h+1) + LEAD_CLKS.
- R8: After a self-refresh ras_n rise, ready rises again exactly PRE_CLKS clocks later.
- R9: we_n is high in every clock cycle.
- R10: A request raised before ready is not serviced until the warm-up has finished. The warm-up count is unchanged, and srf_ack rises exactly 1+SETUP_CLKS clocks after ready first rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous reset, active high; marks power-up |
| srf_req | input | 1 | Self-refresh request, level held by the requester |
| srf_ack | output | 1 | High while the memory is held in self-refresh |
| ready | output | 1 | Memory initialized and idle, free for normal cycles |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low; held inactive |

## Verification
The bound checker watches the timing bounds on every cycle:
- no strobe activity before the pause count is reached,
- the precharge gap ahead of every row-strobe fall,
- column-before-row ordering on entry,
- the minimum self-refresh row-low width,
- the column strobe being up by the time the row strobe rises on exit,
- the strobe levels implied by ready and by the acknowledge.

Only the bench scenarios can show the exact cycle positions: the first activity, the warm-up count, the first ready, and the exit lead. They also show that the row-low width follows max(SRF_CLKS, h+1)+LEAD_CLKS when the release delay is swept across the minimum, and that a request held from before the warm-up is served only after it completes.

// File: rtl/dram_seq_pkg.sv
`timescale 1ns/1ps
package dram_seq_pkg;

   typedef enum logic [3:0] {
      ST_PAUSE,
      ST_INIT_SETUP,
      ST_INIT_RAS,
      ST_INIT_PRE,
      ST_IDLE,
      ST_SRF_SETUP,
      ST_SRF_HOLD,
      ST_SRF_CASUP,
      ST_SRF_PRE
   } seq_state_e;

   // Minimum time in ns to clocks, rounded up.
   function automatic int unsigned ns_to_clk_ceil(int unsigned ns, int unsigned period_ps);
      return (ns * 1000 + period_ps - 1) / period_ps;
   endfunction

   // Maximum time in ns to clocks, rounded down.
   function automatic int unsigned ns_to_clk_floor(int unsigned ns, int unsigned period_ps);
      return (ns * 1000) / period_ps;
   endfunction

   function automatic int unsigned grade_precharge_ns(int unsigned grade);
      case (grade)
         0:       return 90;
         1:       return 110;
         default: return 130;
      endcase
   endfunction

   function automatic int unsigned max_u(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dram_seq_timer.sv
`timescale 1ns/1ps
module dram_seq_timer #(
   parameter int unsigned     CW      = 16,
   parameter logic [CW-1:0]   RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);

   logic [CW-1:0] count_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         count_q <= RST_VAL;
      end else if (load) begin
         count_q <= load_val;
      end else if (count_q != '0) begin
         count_q <= count_q - 1'b1;
      end
   end

   assign zero = (count_q == '0);

endmodule

// File: rtl/dram_seq_fsm.sv
`timescale 1ns/1ps
module dram_seq_fsm
   import dram_seq_pkg::*;
#(
   parameter int unsigned CW          = 16,
   parameter int unsigned INIT_CYCLES = 8,
   parameter bit          INIT_CBR    = 1'b1,
   parameter int unsigned SETUP_CLKS  = 2,
   parameter int unsigned RASLOW_CLKS = 2,
   parameter int unsigned PRE_CLKS    = 18,
   parameter int unsigned SRF_CLKS    = 20000,
   parameter int unsigned LEAD_CLKS   = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          srf_req,
   input  logic          tmr_zero,
   output seq_state_e    state,
   output logic          tmr_load,
   output logic [CW-1:0] tmr_val
);

   localparam int unsigned IW = $clog2(INIT_CYCLES + 1);
   localparam logic [IW-1:0] INIT_LAST = IW'(INIT_CYCLES - 1);

   localparam logic [CW-1:0] SETUP_V  = CW'(SETUP_CLKS - 1);
   localparam logic [CW-1:0] RASLOW_V = CW'(RASLOW_CLKS - 1);
   localparam logic [CW-1:0] PRE_V    = CW'(PRE_CLKS - 1);
   localparam logic [CW-1:0] SRF_V    = CW'(SRF_CLKS - 1);
   localparam logic [CW-1:0] LEAD_V   = CW'((LEAD_CLKS > 0) ? LEAD_CLKS - 1 : 0);

   localparam seq_state_e    INIT_FIRST   = INIT_CBR ? ST_INIT_SETUP : ST_INIT_RAS;
   localparam logic [CW-1:0] INIT_FIRST_V = INIT_CBR ? SETUP_V : RASLOW_V;
   localparam seq_state_e    EXIT_FIRST   = (LEAD_CLKS > 0) ? ST_SRF_CASUP : ST_SRF_PRE;
   localparam logic [CW-1:0] EXIT_FIRST_V = (LEAD_CLKS > 0) ? LEAD_V : PRE_V;

   seq_state_e    state_q, state_d;
   logic [IW-1:0] init_cnt_q;
   logic          init_inc;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      init_inc = 1'b0;
      case (state_q)
         ST_PAUSE: begin
            if (tmr_zero) begin
               state_d  = INIT_FIRST;
               tmr_load = 1'b1;
               tmr_val  = INIT_FIRST_V;
            end
         end
         ST_INIT_SETUP: begin
            if (tmr_zero) begin
               state_d  = ST_INIT_RAS;
               tmr_load = 1'b1;
               tmr_val  = RASLOW_V;
            end
         end
         ST_INIT_RAS: begin
            if (tmr_zero) begin
               state_d  = ST_INIT_PRE;
               tmr_load = 1'b1;
               tmr_val  = PRE_V;
            end
         end
         ST_INIT_PRE: begin
            if (tmr_zero) begin
               init_inc = 1'b1;
               if (init_cnt_q == INIT_LAST) begin
                  state_d = ST_IDLE;
               end else begin
                  state_d  = INIT_FIRST;
                  tmr_load = 1'b1;
                  tmr_val  = INIT_FIRST_V;
               end
            end
         end
         ST_IDLE: begin
            if (srf_req) begin
               state_d  = ST_SRF_SETUP;
               tmr_load = 1'b1;
               tmr_val  = SETUP_V;
            end
         end
         ST_SRF_SETUP: begin
            if (tmr_zero) begin
               state_d  = ST_SRF_HOLD;
               tmr_load = 1'b1;
               tmr_val  = SRF_V;
            end
         end
         ST_SRF_HOLD: begin
            if (tmr_zero && !srf_req) begin
               state_d  = EXIT_FIRST;
               tmr_load = 1'b1;
               tmr_val  = EXIT_FIRST_V;
            end
         end
         ST_SRF_CASUP: begin
            if (tmr_zero) begin
               state_d  = ST_SRF_PRE;
               tmr_load = 1'b1;
               tmr_val  = PRE_V;
            end
         end
         ST_SRF_PRE: begin
            if (tmr_zero) begin
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_PAUSE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q    <= ST_PAUSE;
         init_cnt_q <= '0;
      end else begin
         state_q <= state_d;
         if (init_inc) begin
            init_cnt_q <= init_cnt_q + 1'b1;
         end
      end
   end

   assign state = state_q;

endmodule

// File: rtl/dram_seq_outdec.sv
`timescale 1ns/1ps
module dram_seq_outdec
   import dram_seq_pkg::*;
#(
   parameter bit INIT_CBR = 1'b1
) (
   input  seq_state_e state,
   output logic       ras_n,
   output logic       cas_n,
   output logic       we_n,
   output logic       ready,
   output logic       srf_ack
);

   logic init_cas_low;
   logic srf_cas_low;
   logic ras_low;

   generate
      if (INIT_CBR) begin : g_cbr_init
         assign init_cas_low = (state == ST_INIT_SETUP) || (state == ST_INIT_RAS);
      end else begin : g_ras_only_init
         assign init_cas_low = 1'b0;
      end
   endgenerate

   assign srf_cas_low = (state == ST_SRF_SETUP) || (state == ST_SRF_HOLD);
   assign ras_low     = (state == ST_INIT_RAS) || (state == ST_SRF_HOLD) ||
                        (state == ST_SRF_CASUP);

   assign ras_n   = ~ras_low;
   assign cas_n   = ~(init_cas_low | srf_cas_low);
   assign we_n    = 1'b1;
   assign ready   = (state == ST_IDLE);
   assign srf_ack = (state == ST_SRF_HOLD);

endmodule

// File: rtl/dram_srf_seq.sv
`timescale 1ns/1ps
module dram_srf_seq
   import dram_seq_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_PS = 5000,
   parameter int unsigned PAUSE_NS      = 200000,
   parameter int unsigned INIT_CYCLES   = 8,
   parameter bit          INIT_CBR      = 1'b1,
   parameter int unsigned SETUP_CLKS    = 2,
   parameter int unsigned INIT_RAS_CLKS = 2,
   parameter int unsigned SRF_MIN_NS    = 100000,
   parameter int unsigned SPEED_GRADE   = 0,
   parameter int unsigned CAS_LEAD_NS   = 20
) (
   input  logic clk,
   input  logic rst,
   input  logic srf_req,
   output logic srf_ack,
   output logic ready,
   output logic ras_n,
   output logic cas_n,
   output logic we_n
);

   localparam int unsigned PAUSE_CLKS = ns_to_clk_ceil(PAUSE_NS, CLK_PERIOD_PS);
   localparam int unsigned SRF_CLKS   = ns_to_clk_ceil(SRF_MIN_NS, CLK_PERIOD_PS);
   localparam int unsigned PRE_CLKS   = ns_to_clk_ceil(grade_precharge_ns(SPEED_GRADE), CLK_PERIOD_PS);
   localparam int unsigned LEAD_CLKS  = ns_to_clk_floor(CAS_LEAD_NS, CLK_PERIOD_PS);
   localparam int unsigned MAX_CLKS   = max_u(max_u(PAUSE_CLKS, SRF_CLKS),
                                              max_u(PRE_CLKS, max_u(SETUP_CLKS, INIT_RAS_CLKS)));
   localparam int unsigned CW         = $clog2(MAX_CLKS + 1);

   generate
      if (CLK_PERIOD_PS == 0) begin : g_bad_period
         $error("CLK_PERIOD_PS must be nonzero");
      end
      if (INIT_CYCLES < 8) begin : g_bad_init
         $error("INIT_CYCLES must be at least 8");
      end
      if (SPEED_GRADE > 2) begin : g_bad_grade
         $error("SPEED_GRADE must be 0, 1 or 2");
      end
      if (CAS_LEAD_NS > 50) begin : g_bad_lead
         $error("CAS_LEAD_NS may not exceed 50");
      end
      if (SETUP_CLKS < 1 || INIT_RAS_CLKS < 1) begin : g_bad_widths
         $error("SETUP_CLKS and INIT_RAS_CLKS must be at least 1");
      end
      if (PAUSE_CLKS < 1 || SRF_CLKS < 1) begin : g_bad_times
         $error("pause and self-refresh minimum must be at least one clock");
      end
   endgenerate

   seq_state_e    state;
   logic          tmr_load;
   logic [CW-1:0] tmr_val;
   logic          tmr_zero;

   dram_seq_timer #(
      .CW      (CW),
      .RST_VAL (CW'(PAUSE_CLKS - 1))
   ) timer_i (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   dram_seq_fsm #(
      .CW          (CW),
      .INIT_CYCLES (INIT_CYCLES),
      .INIT_CBR    (INIT_CBR),
      .SETUP_CLKS  (SETUP_CLKS),
      .RASLOW_CLKS (INIT_RAS_CLKS),
      .PRE_CLKS    (PRE_CLKS),
      .SRF_CLKS    (SRF_CLKS),
      .LEAD_CLKS   (LEAD_CLKS)
   ) fsm_i (
      .clk      (clk),
      .rst      (rst),
      .srf_req  (srf_req),
      .tmr_zero (tmr_zero),
      .state    (state),
      .tmr_load (tmr_load),
      .tmr_val  (tmr_val)
   );

   dram_seq_outdec #(
      .INIT_CBR (INIT_CBR)
   ) outdec_i (
      .state   (state),
      .ras_n   (ras_n),
      .cas_n   (cas_n),
      .we_n    (we_n),
      .ready   (ready),
      .srf_ack (srf_ack)
   );

endmodule

// File: rtl/dram_seq_chk.sv
`timescale 1ns/1ps
module dram_seq_chk #(
   parameter int unsigned PAUSE_CLKS = 40000,
   parameter int unsigned SRF_CLKS   = 20000,
   parameter int unsigned PRE_CLKS   = 18,
   parameter bit          INIT_CBR   = 1'b1
) (
   input logic clk,
   input logic rst,
   input logic ras_n,
   input logic cas_n,
   input logic ready,
   input logic srf_ack
);

   logic [31:0] since_rst;
   logic [31:0] ras_low_cnt;
   logic [31:0] ras_high_cnt;
   logic        in_srf;

   always_ff @(posedge clk) begin
      if (rst) begin
         since_rst    <= '0;
         ras_low_cnt  <= '0;
         ras_high_cnt <= '0;
         in_srf       <= 1'b0;
      end else begin
         if (since_rst < 32'(PAUSE_CLKS)) since_rst <= since_rst + 1'b1;
         if (ras_n) begin
            ras_low_cnt <= '0;
            if (ras_high_cnt != '1) ras_high_cnt <= ras_high_cnt + 1'b1;
         end else begin
            ras_high_cnt <= '0;
            if (ras_low_cnt != '1) ras_low_cnt <= ras_low_cnt + 1'b1;
         end
         if (srf_ack) in_srf <= 1'b1;
         else if (ras_n) in_srf <= 1'b0;
      end
   end

   a_r1_pause_quiet: assert property (@(posedge clk) disable iff (rst)
      (!ras_n || !cas_n) |-> (since_rst >= 32'(PAUSE_CLKS)));

   a_r3_precharge_gap: assert property (@(posedge clk) disable iff (rst)
      $fell(ras_n) |-> (ras_high_cnt >= 32'(PRE_CLKS)));

   a_r4_ready_strobes_idle: assert property (@(posedge clk) disable iff (rst)
      ready |-> (ras_n && cas_n && !srf_ack));

   a_r5_cas_before_ras: assert property (@(posedge clk) disable iff (rst)
      ($fell(ras_n) && (INIT_CBR || srf_ack)) |-> !cas_n);

   a_r5_ack_strobes_low: assert property (@(posedge clk) disable iff (rst)
      srf_ack |-> (!ras_n && !cas_n));

   a_r6_srf_min_width: assert property (@(posedge clk) disable iff (rst)
      ($rose(ras_n) && in_srf) |-> (ras_low_cnt >= 32'(SRF_CLKS)));

   a_r7_cas_up_by_exit: assert property (@(posedge clk) disable iff (rst)
      ($rose(ras_n) && in_srf) |-> cas_n);

endmodule

bind dram_srf_seq dram_seq_chk #(
   .PAUSE_CLKS (PAUSE_CLKS),
   .SRF_CLKS   (SRF_CLKS),
   .PRE_CLKS   (PRE_CLKS),
   .INIT_CBR   (INIT_CBR)
) chk_i (
   .clk     (clk),
   .rst     (rst),
   .ras_n   (ras_n),
   .cas_n   (cas_n),
   .ready   (ready),
   .srf_ack (srf_ack)
);

// File: tb/dram_srf_seq_tb_top.sv
`timescale 1ns/1ps
module dram_srf_seq_tb_top;

   localparam int PERIOD_PS = 5000;
   localparam int PAUSE_NS  = 2000;
   localparam int SRF_NS    = 1000;
   localparam int GRADE     = 1;
   localparam int LEAD_NS   = 20;
   localparam int INIT_N    = 8;
   localparam int SETUP     = 2;
   localparam int RASLOW    = 2;

   localparam int PAUSE = (PAUSE_NS * 1000 + PERIOD_PS - 1) / PERIOD_PS;
   localparam int SRF   = (SRF_NS * 1000 + PERIOD_PS - 1) / PERIOD_PS;
   localparam int PRE   = (110 * 1000 + PERIOD_PS - 1) / PERIOD_PS;
   localparam int LEAD  = (LEAD_NS * 1000) / PERIOD_PS;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic srf_req = 1'b0;
   logic srf_ack, ready, ras_n, cas_n, we_n;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   dram_srf_seq #(
      .CLK_PERIOD_PS (PERIOD_PS),
      .PAUSE_NS      (PAUSE_NS),
      .INIT_CYCLES   (INIT_N),
      .INIT_CBR      (1'b1),
      .SETUP_CLKS    (SETUP),
      .INIT_RAS_CLKS (RASLOW),
      .SRF_MIN_NS    (SRF_NS),
      .SPEED_GRADE   (GRADE),
      .CAS_LEAD_NS   (LEAD_NS)
   ) dut_i (
      .clk     (clk),
      .rst     (rst),
      .srf_req (srf_req),
      .srf_ack (srf_ack),
      .ready   (ready),
      .ras_n   (ras_n),
      .cas_n   (cas_n),
      .we_n    (we_n)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Edge monitor, sampled on the falling clock edge.
   int t = -1;
   bit pr = 1'b1, pc = 1'b1, prdy = 1'b0;
   int t_cf = 0, t_rf = 0, t_rr = -1, t_cr = 0;
   int t_rdy_first = -1, t_rdy_last = -1, first_act = -1;
   int init_pulses = 0, srf_w = -1, srf_lead = -1;
   bit ack_in = 1'b0, we_bad = 1'b0, rdy_bad = 1'b0;

   always @(negedge clk) begin
      if (!rst) begin
         t++;
         if (!we_n) we_bad = 1'b1;
         if (ready && (!ras_n || !cas_n || srf_ack)) rdy_bad = 1'b1;
         if (first_act < 0 && (!ras_n || !cas_n)) first_act = t;
         if (pc && !cas_n) t_cf = t;
         if (!pc && cas_n) t_cr = t;
         if (srf_ack && !ras_n) ack_in = 1'b1;
         if (pr && !ras_n) begin
            if (t_rdy_first < 0)
               chk(!cas_n && (t - t_cf) == SETUP, "R2 cas-to-ras setup", t - t_cf, SETUP);
            else
               chk(!cas_n && (t - t_cf) == SETUP, "R5 cas-to-ras setup", t - t_cf, SETUP);
            if (t_rr >= 0) chk((t - t_rr) >= PRE, "R3 precharge gap", t - t_rr, PRE);
            t_rf   = t;
            ack_in = srf_ack;
         end
         if (!pr && ras_n) begin
            if (ack_in) begin
               srf_w    = t - t_rf;
               srf_lead = t - t_cr;
            end else begin
               chk((t - t_rf) == RASLOW, "R2 warm-up ras width", t - t_rf, RASLOW);
               init_pulses++;
            end
            t_rr   = t;
            ack_in = 1'b0;
         end
         if (!prdy && ready) begin
            if (t_rdy_first < 0) t_rdy_first = t;
            t_rdy_last = t;
         end
         pr   = ras_n;
         pc   = cas_n;
         prdy = ready;
      end
   end

   task automatic finish_srf(input int h);
      int exp_w;
      repeat (h) @(negedge clk);
      #1 srf_req = 1'b0;
      @(negedge clk);
      #1;
      while (!ready) begin
         @(negedge clk);
         #1;
      end
      exp_w = ((h + 1 > SRF) ? h + 1 : SRF) + LEAD;
      chk(srf_w == exp_w, "R6 R7 self-refresh ras width", srf_w, exp_w);
      chk(srf_w >= SRF, "R6 minimum width", srf_w, SRF);
      chk(srf_lead == LEAD, "R7 cas lead on exit", srf_lead, LEAD);
      chk((t_rdy_last - t_rr) == PRE, "R8 precharge before ready", t_rdy_last - t_rr, PRE);
   endtask

   task automatic srf_cycle(input int h);
      int treq;
      @(negedge clk);
      #1 srf_req = 1'b1;
      treq = t;
      @(negedge clk);
      #1;
      while (!srf_ack) begin
         @(negedge clk);
         #1;
      end
      chk((t - treq) == 1 + SETUP, "R5 ack delay", t - treq, 1 + SETUP);
      chk(!ras_n && !cas_n, "R5 strobes low at ack", {30'd0, ras_n, cas_n}, 0);
      finish_srf(h);
   endtask

   task automatic run_all();
      int exp_rdy;
      int hs[7] = '{1, 50, 198, 199, 200, 201, 350};
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(ras_n && cas_n && !ready && !srf_ack, "R1 reset state",
          {28'd0, ras_n, cas_n, ready, srf_ack}, 4'b1100);
      @(posedge clk);
      #1 rst = 1'b0;
      wait (t >= 50);
      @(negedge clk);
      #1 srf_req = 1'b1;
      chk(!srf_ack && !ready, "R10 no ack during pause", {30'd0, srf_ack, ready}, 0);
      @(negedge clk);
      #1;
      while (!srf_ack) begin
         @(negedge clk);
         #1;
      end
      exp_rdy = PAUSE + INIT_N * (SETUP + RASLOW + PRE);
      chk(first_act == PAUSE, "R1 first activity", first_act, PAUSE);
      chk(init_pulses == INIT_N, "R2 warm-up count", init_pulses, INIT_N);
      chk(t_rdy_first == exp_rdy, "R4 first ready", t_rdy_first, exp_rdy);
      chk(t == exp_rdy + 1 + SETUP, "R10 early request served after warm-up", t, exp_rdy + 1 + SETUP);
      finish_srf(10);
      foreach (hs[i]) srf_cycle(hs[i]);
      chk(init_pulses == INIT_N, "R10 warm-up count unchanged", init_pulses, INIT_N);
      chk(!we_bad, "R9 we_n held high", we_bad, 0);
      chk(!rdy_bad, "R4 ready only when idle", rdy_bad, 0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (20000) @(posedge clk);
            chk(1'b0, "watchdog expired", 0, 1);
         end
      join_any
      disable fork;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule